// File: doc/BRIEF.md
# Hardware Cursor Overlay Compositor

This block is a single pixel-rate stage placed between the pixel fetch logic and the video output of a display pipeline. Each clock it can accept one 8-bit indexed framebuffer pixel along with that pixel's screen column and row. It returns one 24-bit RGB value one cycle later. The RGB value comes from one of two places: the 256-entry colour lookup table, or a small hardware cursor laid over the picture.

The cursor is a 64 by 64 image with two bits per pixel, stored as 512 sixteen-bit words. Code 0 lets the framebuffer show through. Codes 1 to 3 pick one of three cursor colours. A packed position word sets where the cursor's top-left corner sits on the screen. A control word has two effects: it can hide the cursor, and it can force the whole output to black.

Software loads every table and register through a plain write port that carries a word address and 32 bits of data. The block does not generate video timing or fetch memory.

Top module: `cursor_overlay`

## Requirements
- R1: After reset, `outValid` is 0 and `outRgb` is 0. The colour tables, cursor colours, pattern words and position are all zero. The cursor starts enabled at (0,0) with an all-transparent pattern, so any pixel yields black.
- R2: `outValid` equals `pixValid` delayed by one clock, and `outRgb` updates one clock after a valid pixel. `outRgb` holds its value while `pixValid` is low. Back-to-back pixels stream at one per cycle.
- R3: Writing word address 0x100+i loads colour table entry i with red = data[23:16], green = data[15:8] and blue = data[7:0]. A pixel not covered by a visible cursor code outputs the entry selected by `pixIndex` as {red, green, blue}.
- R4: A pixel lies inside the cursor when cx <= x < cx+64 and cy <= y < cy+64. Pixels one column or row beyond those bounds are not covered.
- R5: Pattern word k (0 to 511) is written at word address 0x200+k. For a pixel inside the cursor with dx = x-cx and dy = y-cy, the word used is dy*8 + dx/8. The 2-bit code sits at bits ((dx mod 8)*2)+1 : (dx mod 8)*2.
- R6: Code 0 is transparent and shows the colour table entry. Codes 1, 2 and 3 output cursor colours 0, 1 and 2. Those colours are written at word addresses 0x004, 0x005 and 0x006 with the same byte layout as R3.
- R7: While control bit 23 is set, the cursor is hidden and every pixel uses the colour table. The control word is written at word address 0x000.
- R8: While control bit 10 is set, every output pixel is black, cursor pixels included.
- R9: The position word is written at word address 0x001. The cursor column cx is data[23:12] and the cursor row cy is data[11:0].

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Pixel clock |
| rstN | input | 1 | Asynchronous active-low reset |
| regWe | input | 1 | Register write strobe |
| regAddr | input | 10 | Word address of the write |
| regData | input | 32 | Write data |
| pixValid | input | 1 | Input pixel qualifier |
| pixIndex | input | 8 | Framebuffer colour index |
| pixX | input | 12 | Screen column of the pixel |
| pixY | input | 12 | Screen row of the pixel |
| outValid | output | 1 | Output pixel qualifier |
| outRgb | output | 24 | Composited colour {red, green, blue} |

## Verification
Pixels are sent at the cursor's four corners and one step past each edge. The pattern words that a wrapped or off-by-one offset would select are filled with opaque codes, so a wrong bound shows up as a wrong colour. A mid-row word with a single code at a high bit offset separates correct word selection from correct bit selection. Three adjacent columns carrying codes 1, 2 and 3 separate the three cursor colours from the transparent case. The same cursor pixels are then resent with the hide bit set and with the blank bit set, which shows the priority order. A final gap-free burst checks the one-cycle latency under streaming.

// File: rtl/cursor_ovl_pkg.sv
package cursor_ovl_pkg;
  localparam int TBL_IDX_W = 9;

  // Strobes and payload from the register decoder to the datapath tables
  typedef struct packed {
    logic                 palWe;
    logic                 curColWe;
    logic                 patWe;
    logic [TBL_IDX_W-1:0] idx;
    logic [31:0]          data;
  } tblWrite_t;
endpackage

// File: rtl/cursor_ovl_ctrl.sv
module cursor_ovl_ctrl
  import cursor_ovl_pkg::*;
#(
  parameter int ADDR_W  = 10,
  parameter int COORD_W = 12
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               regWe,
  input  logic [ADDR_W-1:0]  regAddr,
  input  logic [31:0]        regData,
  output tblWrite_t          wrStb,
  output logic               blankOn,
  output logic               cursorOn,
  output logic [COORD_W-1:0] curX,
  output logic [COORD_W-1:0] curY
);
  localparam int PAT_SEL = ADDR_W - 1;
  localparam int PAL_SEL = ADDR_W - 2;
  localparam logic [ADDR_W-1:0] CTRL_ADDR = ADDR_W'(0);
  localparam logic [ADDR_W-1:0] POS_ADDR  = ADDR_W'(1);
  localparam logic [ADDR_W-1:0] CC0_ADDR  = ADDR_W'(4);
  localparam logic [ADDR_W-1:0] CC2_ADDR  = ADDR_W'(6);

  logic blankReg, hideReg;
  logic [2*COORD_W-1:0] posReg;
  logic isLow;

  assign isLow = (regAddr[PAT_SEL:PAL_SEL] == 2'b00);

  always_comb begin
    wrStb          = '0;
    wrStb.data     = regData;
    wrStb.idx      = TBL_IDX_W'(regAddr[PAT_SEL-1:0]);
    wrStb.patWe    = regWe && regAddr[PAT_SEL];
    wrStb.palWe    = regWe && (regAddr[PAT_SEL:PAL_SEL] == 2'b01);
    wrStb.curColWe = regWe && isLow && regAddr >= CC0_ADDR && regAddr <= CC2_ADDR;
    if (wrStb.curColWe) wrStb.idx = TBL_IDX_W'(regAddr - CC0_ADDR);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      blankReg <= 1'b0;
      hideReg  <= 1'b0;
      posReg   <= '0;
    end else if (regWe) begin
      if (regAddr == CTRL_ADDR) begin
        blankReg <= regData[10];
        hideReg  <= regData[23];
      end
      if (regAddr == POS_ADDR) posReg <= regData[2*COORD_W-1:0];
    end
  end

  assign blankOn  = blankReg;
  assign cursorOn = !hideReg;
  assign curX     = posReg[2*COORD_W-1:COORD_W];
  assign curY     = posReg[COORD_W-1:0];
endmodule

// File: rtl/cursor_ovl_datapath.sv
module cursor_ovl_datapath
  import cursor_ovl_pkg::*;
#(
  parameter int COORD_W = 12,
  parameter int IDX_W   = 8,
  parameter int CUR_DIM = 64
) (
  input  logic               clk,
  input  logic               rstN,
  input  tblWrite_t          wrStb,
  input  logic               blankOn,
  input  logic               cursorOn,
  input  logic [COORD_W-1:0] curX,
  input  logic [COORD_W-1:0] curY,
  input  logic               pixValid,
  input  logic [IDX_W-1:0]   pixIndex,
  input  logic [COORD_W-1:0] pixX,
  input  logic [COORD_W-1:0] pixY,
  output logic               cursorHit,
  output logic               outValid,
  output logic [23:0]        outRgb
);
  localparam int PAL_DEPTH = 2 ** IDX_W;
  localparam int PIX_PER_W = 8;
  localparam int OFF_W     = $clog2(CUR_DIM);
  localparam int COL_W     = $clog2(PIX_PER_W);
  localparam int PAT_WORDS = CUR_DIM * CUR_DIM / PIX_PER_W;
  localparam int PAT_IDX_W = $clog2(PAT_WORDS);
  localparam logic [COORD_W:0] DIM_V = (COORD_W+1)'(CUR_DIM);

  logic [23:0] palette [PAL_DEPTH];
  logic [23:0] curCol  [3];
  logic [15:0] pattern [PAT_WORDS];

  logic [COORD_W:0] dx, dy;
  logic inX, inY;
  logic [PAT_IDX_W-1:0] wordIdx;
  logic [15:0] patWord;
  logic [1:0]  code;
  logic [23:0] nextRgb;
  logic unusedHighData;

  assign unusedHighData = ^wrStb.data[31:24];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int i = 0; i < PAL_DEPTH; i++) palette[i] <= '0;
      for (int i = 0; i < 3; i++)         curCol[i]  <= '0;
      for (int i = 0; i < PAT_WORDS; i++) pattern[i] <= '0;
    end else begin
      if (wrStb.palWe)    palette[wrStb.idx[IDX_W-1:0]] <= wrStb.data[23:0];
      if (wrStb.curColWe) curCol[wrStb.idx[1:0]]        <= wrStb.data[23:0];
      if (wrStb.patWe)    pattern[wrStb.idx[PAT_IDX_W-1:0]] <= wrStb.data[15:0];
    end
  end

  // Offsets from the cursor corner; the extra top bit flags a negative offset
  assign dx  = {1'b0, pixX} - {1'b0, curX};
  assign dy  = {1'b0, pixY} - {1'b0, curY};
  assign inX = !dx[COORD_W] && (dx < DIM_V);
  assign inY = !dy[COORD_W] && (dy < DIM_V);
  assign cursorHit = cursorOn && inX && inY;

  assign wordIdx = {dy[OFF_W-1:0], dx[OFF_W-1:COL_W]};
  assign patWord = pattern[wordIdx];
  assign code    = patWord[{dx[COL_W-1:0], 1'b0} +: 2];

  always_comb begin
    nextRgb = palette[pixIndex];
    if (cursorHit) begin
      case (code)
        2'd1:    nextRgb = curCol[0];
        2'd2:    nextRgb = curCol[1];
        2'd3:    nextRgb = curCol[2];
        default: nextRgb = palette[pixIndex];
      endcase
    end
    if (blankOn) nextRgb = '0;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      outValid <= 1'b0;
      outRgb   <= '0;
    end else begin
      outValid <= pixValid;
      if (pixValid) outRgb <= nextRgb;
    end
  end
endmodule

// File: rtl/cursor_overlay.sv
module cursor_overlay
  import cursor_ovl_pkg::*;
#(
  parameter int ADDR_W  = 10,
  parameter int COORD_W = 12,
  parameter int IDX_W   = 8,
  parameter int CUR_DIM = 64
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               regWe,
  input  logic [ADDR_W-1:0]  regAddr,
  input  logic [31:0]        regData,
  input  logic               pixValid,
  input  logic [IDX_W-1:0]   pixIndex,
  input  logic [COORD_W-1:0] pixX,
  input  logic [COORD_W-1:0] pixY,
  output logic               outValid,
  output logic [23:0]        outRgb
);
  tblWrite_t wrStb;
  logic blankOn, cursorOn, cursorHit;
  logic [COORD_W-1:0] curX, curY;

  cursor_ovl_ctrl #(.ADDR_W(ADDR_W), .COORD_W(COORD_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .regWe(regWe), .regAddr(regAddr), .regData(regData),
    .wrStb(wrStb), .blankOn(blankOn), .cursorOn(cursorOn), .curX(curX), .curY(curY)
  );

  cursor_ovl_datapath #(.COORD_W(COORD_W), .IDX_W(IDX_W), .CUR_DIM(CUR_DIM)) u_dp (
    .clk(clk), .rstN(rstN), .wrStb(wrStb), .blankOn(blankOn), .cursorOn(cursorOn),
    .curX(curX), .curY(curY), .pixValid(pixValid), .pixIndex(pixIndex),
    .pixX(pixX), .pixY(pixY), .cursorHit(cursorHit), .outValid(outValid), .outRgb(outRgb)
  );
endmodule

// File: rtl/cursor_ovl_chk.sv
module cursor_ovl_chk #(
  parameter int COORD_W = 12
) (
  input logic               clk,
  input logic               rstN,
  input logic               pixValid,
  input logic [COORD_W-1:0] pixX,
  input logic [COORD_W-1:0] pixY,
  input logic [COORD_W-1:0] curX,
  input logic [COORD_W-1:0] curY,
  input logic               blankOn,
  input logic               cursorOn,
  input logic               cursorHit,
  input logic               outValid,
  input logic [23:0]        outRgb
);
  // R1
  reset_state_chk: assert property (@(posedge clk)
    !rstN |=> (!outValid && outRgb == 24'd0));

  // R2
  valid_follow_chk: assert property (@(posedge clk) disable iff (!rstN)
    pixValid |=> outValid);

  // R2
  valid_drop_chk: assert property (@(posedge clk) disable iff (!rstN)
    !pixValid |=> !outValid);

  // R2
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !pixValid |=> $stable(outRgb));

  // R4
  hit_range_chk: assert property (@(posedge clk) disable iff (!rstN)
    cursorHit |-> (pixX >= curX && pixY >= curY));

  // R7
  hidden_no_hit_chk: assert property (@(posedge clk) disable iff (!rstN)
    !cursorOn |-> !cursorHit);

  // R8
  blank_black_chk: assert property (@(posedge clk) disable iff (!rstN)
    (pixValid && blankOn) |=> outRgb == 24'd0);
endmodule

bind cursor_overlay cursor_ovl_chk #(.COORD_W(COORD_W)) u_chk (
  .clk(clk), .rstN(rstN), .pixValid(pixValid), .pixX(pixX), .pixY(pixY),
  .curX(curX), .curY(curY), .blankOn(blankOn), .cursorOn(cursorOn),
  .cursorHit(cursorHit), .outValid(outValid), .outRgb(outRgb)
);

// File: tb/test_cursor_overlay.sv
module test_cursor_overlay;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        regWe = 1'b0;
  logic [9:0]  regAddr = '0;
  logic [31:0] regData = '0;
  logic        pixValid = 1'b0;
  logic [7:0]  pixIndex = '0;
  logic [11:0] pixX = '0, pixY = '0;
  logic        outValid;
  logic [23:0] outRgb;

  int checks = 0, fails = 0;
  bit finished = 1'b0;

  // Reference state, built from the requirement text
  int palM [256];
  int curM [3];
  int patM [512];
  bit blankM = 1'b0, hideM = 1'b0;
  int cxM = 0, cyM = 0;

  logic [23:0] expQ [$];
  string       tagQ [$];

  cursor_overlay i_cursor_overlay (
    .clk(clk), .rstN(rstN), .regWe(regWe), .regAddr(regAddr), .regData(regData),
    .pixValid(pixValid), .pixIndex(pixIndex), .pixX(pixX), .pixY(pixY),
    .outValid(outValid), .outRgb(outRgb)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic logic [23:0] model(int x, int y, int idx);
    if (blankM) return 24'd0;
    if (!hideM && x >= cxM && x < cxM + 64 && y >= cyM && y < cyM + 64) begin
      int dx = x - cxM;
      int dy = y - cyM;
      int w = patM[dy*8 + dx/8];
      int c = (w >> ((dx % 8) * 2)) & 3;
      if (c != 0) return curM[c-1][23:0];
    end
    return palM[idx][23:0];
  endfunction

  task automatic check(string tag, logic [23:0] act, logic [23:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %06h expected %06h", tag, act, exp);
    end
  endtask

  task automatic writeReg(int addr, int data);
    regWe = 1'b1; regAddr = addr[9:0]; regData = data;
    if (addr == 0) begin blankM = data[10]; hideM = data[23]; end
    if (addr == 1) begin cxM = (data >> 12) & 12'hfff; cyM = data & 12'hfff; end
    if (addr >= 4 && addr <= 6) curM[addr-4] = data & 24'hffffff;
    if (addr >= 'h100 && addr < 'h200) palM[addr-'h100] = data & 24'hffffff;
    if (addr >= 'h200 && addr < 'h400) patM[addr-'h200] = data & 16'hffff;
    @(negedge clk);
    regWe = 1'b0;
  endtask

  task automatic sendPix(int x, int y, int idx, string tag);
    pixValid = 1'b1; pixX = x[11:0]; pixY = y[11:0]; pixIndex = idx[7:0];
    expQ.push_back(model(x, y, idx));
    tagQ.push_back(tag);
    @(negedge clk);
  endtask

  task automatic idle();
    pixValid = 1'b0;
    @(negedge clk);
    @(negedge clk);
  endtask

  // Monitor: compares each produced pixel with the head of the scoreboard
  always @(negedge clk) begin
    if (rstN && outValid) begin
      if (expQ.size() == 0) begin
        checks++; fails++;
        $display("FAIL R2: actual unexpected valid output expected none");
      end else begin
        logic [23:0] e;
        string t;
        e = expQ.pop_front();
        t = tagQ.pop_front();
        check(t, outRgb, e);
      end
    end
  end

  task automatic summary();
    if (expQ.size() != 0) begin
      checks++; fails++;
      $display("FAIL R2: actual %0d outputs missing expected 0", expQ.size());
    end
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    finished = 1'b1;
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      checks++; fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      summary();
    end
  end

  initial begin
    for (int i = 0; i < 256; i++) palM[i] = 0;
    for (int i = 0; i < 512; i++) patM[i] = 0;
    for (int i = 0; i < 3; i++)   curM[i] = 0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R1 reset state
    check("R1 outRgb", outRgb, 24'd0);
    check("R1 outValid", {23'd0, outValid}, 24'd0);
    sendPix(5, 5, 3, "R1 zero tables");
    sendPix(0, 0, 200, "R1 cursor corner");
    idle();

    // R3 colour table
    writeReg('h103, 'hFF123456);
    writeReg('h180, 'h00AABBCC);
    writeReg('h1FF, 'h00010203);
    sendPix(300, 300, 3, "R3 entry 3");
    sendPix(300, 301, 'h80, "R3 entry 128");
    sendPix(300, 302, 'hFF, "R3 last entry");
    idle();

    // R6 cursor colours, R9 position
    writeReg(4, 'h00110000);
    writeReg(5, 'h00002200);
    writeReg(6, 'h00000033);
    writeReg(1, (100 << 12) | 50);
    // R5 pattern words
    writeReg('h200 + 0, 'h0039);
    writeReg('h200 + 511, 'hC000);
    writeReg('h200 + 7, 'hFFFF);
    writeReg('h200 + 504, 'hFFFF);
    writeReg('h200 + 10, 'h3000);
    sendPix(100, 50, 3, "R6 code1 R9 corner");
    sendPix(101, 50, 3, "R6 code2");
    sendPix(102, 50, 3, "R6 code3");
    sendPix(103, 50, 3, "R6 code0 transparent");
    sendPix(163, 113, 3, "R4 last inside");
    sendPix(164, 113, 3, "R4 right edge outside");
    sendPix(163, 114, 3, "R4 bottom edge outside");
    sendPix(99, 50, 3, "R4 left outside");
    sendPix(100, 49, 3, "R4 top outside");
    sendPix(163, 50, 3, "R4 top-right inside");
    sendPix(100, 113, 'h80, "R4 bottom-left inside");
    sendPix(122, 51, 3, "R5 word10 high offset");
    sendPix(121, 51, 3, "R5 word10 neighbour");
    idle();

    // R7 cursor hidden
    writeReg(0, 32'h0080_0000);
    sendPix(100, 50, 3, "R7 hidden code1");
    sendPix(163, 113, 'hFF, "R7 hidden code3");
    idle();

    // R8 blank overrides everything
    writeReg(0, 32'h0000_0400);
    sendPix(100, 50, 3, "R8 blank cursor");
    sendPix(300, 300, 'h80, "R8 blank table");
    idle();
    writeReg(0, 0);

    // R2 gap-free burst
    for (int k = 0; k < 16; k++) sendPix(96 + k, 50, (k * 17) & 255, "R2 burst");
    idle();
    summary();
  end
endmodule